// File: doc/BRIEF.md
# Interleaved Line-Fill Sequencer

This block services a cache-line read miss from a bank of memory modules that are interleaved on the low-order word address bits. When a miss request arrives, the sequencer latches the line address and broadcasts it once. Each module then loads its own address buffer with the first word it owns and starts a slow first access. Later words in the same row follow after a shorter access time. Each finished word waits in that module's data buffer until the shared return path is free.

The return path drains the modules in strict ascending word order and delivers one word per cycle with a valid strobe and a word index. A done pulse comes with the last word. With four modules, the second group of accesses overlaps the delivery of the first group. An 8-word line then completes 15 cycles after the request, where one module alone would need 36. The module count is a parameter, so the same RTL can also be built as a single non-interleaved module. A cycle counter reports how long each fill took.

Top module: `ilv_line_fill`

## Requirements
- R1: After reset, `valid_o`, `done_o` and `busy_o` are low and `fill_cycles_o` is zero.
- R2: A request sampled while `busy_o` is low is accepted, and `busy_o` is high in the cycle after that edge. `busy_o` stays high until the cycle in which `done_o` is high, and in that cycle `busy_o` is low.
- R3: A request presented while `busy_o` is high is ignored. The words of the fill in progress are unchanged, and no further words appear after that fill ends.
- R4: The line address is captured at acceptance. Word k of line L has word address w = L*LINE_WORDS + k. It is fetched from module w mod NUM_MODS, at address w / NUM_MODS within that module.
- R5: Each returned data word equals ((w * 40503) XOR 0x3C96), truncated to 16 bits, where w is its 16-bit word address. This is the storage pattern the modules model.
- R6: Words are returned in ascending order. `idx_o` is 3 bits and counts 0 to 7, with exactly one `valid_o` cycle per word.
- R7: With four modules, word k is presented with `valid_o` high in the cycle after edge 8+k, counting the accepting edge as edge 0.
- R8: `done_o` is a single-cycle pulse. It is high only together with `valid_o` for word index 7.
- R9: In the cycle with `done_o`, `fill_cycles_o` equals the number of edges from acceptance to the last word: 15 with four modules.
- R10: With a single module, word k is presented after edge 8+4k, and `fill_cycles_o` reads 36 at done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Miss request, accepted when idle |
| line_i | input | 13 | Line address (word address without the 3 index bits) |
| busy_o | output | 1 | Fill in progress |
| valid_o | output | 1 | Returned word valid |
| idx_o | output | 3 | Index of the returned word within the line |
| data_o | output | 16 | Returned data word |
| done_o | output | 1 | Last word of the line |
| fill_cycles_o | output | 8 | Edges counted since acceptance of the current or last fill |

## Verification
All timing is counted from the accepting edge. There is one address-issue edge and then six latency edges before the first buffer fills. Word k is therefore due after edge 8+k with four modules, and after edge 8+4k with one module. Done and the cycle count are due with the last word, after edge 15 or edge 36. The bench walks every edge of each fill and samples at the falling edge after each edge. At that point it compares valid, index, data, done and busy against the values computed for that edge number. A sweep over many line addresses covers every module and both address extremes.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    FILL_IDLE,
    FILL_ISSUE,
    FILL_STREAM
  } fill_state_e;

  // modelled storage contents of the memory modules
  function automatic logic [31:0] word_pattern(input logic [31:0] a);
    return (a * 32'd40503) ^ 32'h3C96;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int MOD_IDX   = 0,
  parameter int NUM_MODS  = 4,
  parameter int WPM       = 2,
  parameter int IADDR_W   = 14,
  parameter int DATA_W    = 16,
  parameter int FIRST_LAT = 6,
  parameter int NEXT_LAT  = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [IADDR_W-1:0] base_i,
  input  logic               drain_i,
  output logic               full_o,
  output logic [DATA_W-1:0]  data_o
);
  import ilv_pkg::*;

  localparam int MAX_LAT = (FIRST_LAT > NEXT_LAT) ? FIRST_LAT : NEXT_LAT;
  localparam int LAT_W   = $clog2(MAX_LAT + 1);
  localparam int LEFT_W  = $clog2(WPM + 1);
  localparam int MSHIFT  = $clog2(NUM_MODS);

  logic [IADDR_W-1:0] abr_q;
  logic [DATA_W-1:0]  dbr_q;
  logic               full_q;
  logic [LAT_W-1:0]   lat_q;
  logic [LEFT_W-1:0]  left_q;
  logic               active_q;
  logic               fetch_done;
  logic               load;
  logic [31:0]        word_addr;

  assign word_addr  = (32'(abr_q) << MSHIFT) | 32'(MOD_IDX);
  assign fetch_done = active_q && (lat_q == LAT_W'(1));
  // finished access waits while the buffer still holds an undelivered word
  assign load       = fetch_done && (!full_q || drain_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abr_q    <= '0;
      lat_q    <= '0;
      left_q   <= '0;
      active_q <= 1'b0;
    end else if (launch_i) begin
      abr_q    <= base_i;
      lat_q    <= LAT_W'(FIRST_LAT);
      left_q   <= LEFT_W'(WPM);
      active_q <= 1'b1;
    end else if (active_q) begin
      if (lat_q > LAT_W'(1)) begin
        lat_q <= lat_q - LAT_W'(1);
      end else if (load) begin
        abr_q  <= abr_q + IADDR_W'(1);
        left_q <= left_q - LEFT_W'(1);
        lat_q  <= LAT_W'(NEXT_LAT);
        if (left_q == LEFT_W'(1)) active_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbr_q  <= '0;
      full_q <= 1'b0;
    end else if (load) begin
      dbr_q  <= DATA_W'(word_pattern(word_addr));
      full_q <= 1'b1;
    end else if (drain_i) begin
      full_q <= 1'b0;
    end
  end

  assign full_o = full_q;
  assign data_o = dbr_q;

endmodule

// File: rtl/ilv_return.sv
module ilv_return #(
  parameter int NUM_MODS   = 4,
  parameter int LINE_WORDS = 8,
  parameter int DATA_W     = 16
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             stream_i,
  input  logic [$clog2(LINE_WORDS)-1:0]    widx_i,
  input  logic [NUM_MODS-1:0]              full_i,
  input  logic [NUM_MODS-1:0][DATA_W-1:0]  data_i,
  output logic [NUM_MODS-1:0]              drain_o,
  output logic                             take_o,
  output logic                             valid_o,
  output logic [$clog2(LINE_WORDS)-1:0]    idx_o,
  output logic [DATA_W-1:0]                data_o,
  output logic                             done_o
);
  localparam int IDX_W = $clog2(LINE_WORDS);
  localparam int SEL_W = (NUM_MODS > 1) ? $clog2(NUM_MODS) : 1;

  logic [SEL_W-1:0]  sel;
  logic              take;
  logic              valid_q;
  logic              done_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] data_q;

  assign sel  = SEL_W'(32'(widx_i) % NUM_MODS);
  assign take = stream_i && full_i[sel];

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_drain
    assign drain_o[m] = take && (sel == SEL_W'(m));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      data_q  <= '0;
    end else begin
      valid_q <= take;
      done_q  <= take && (widx_i == IDX_W'(LINE_WORDS - 1));
      if (take) begin
        idx_q  <= widx_i;
        data_q <= data_i[sel];
      end
    end
  end

  assign take_o  = take;
  assign valid_o = valid_q;
  assign idx_o   = idx_q;
  assign data_o  = data_q;
  assign done_o  = done_q;

endmodule

// File: rtl/ilv_fill_ctrl.sv
module ilv_fill_ctrl #(
  parameter int NUM_MODS   = 4,
  parameter int LINE_WORDS = 8,
  parameter int ADDR_W     = 16,
  parameter int CYC_W      = 8
) (
  input  logic                                                     clk_i,
  input  logic                                                     rst_ni,
  input  logic                                                     req_i,
  input  logic [ADDR_W-$clog2(LINE_WORDS)-1:0]                     line_i,
  input  logic                                                     take_i,
  output logic                                                     launch_o,
  output logic                                                     stream_o,
  output logic                                                     busy_o,
  output logic [$clog2(LINE_WORDS)-1:0]                            widx_o,
  output logic [NUM_MODS-1:0][ADDR_W-$clog2(NUM_MODS)-1:0]         base_o,
  output logic [CYC_W-1:0]                                         fill_cycles_o
);
  import ilv_pkg::*;

  localparam int IDX_W   = $clog2(LINE_WORDS);
  localparam int LINE_W  = ADDR_W - IDX_W;
  localparam int MSHIFT  = $clog2(NUM_MODS);
  localparam int IADDR_W = ADDR_W - MSHIFT;

  fill_state_e       state_q;
  logic [LINE_W-1:0] line_q;
  logic [IDX_W-1:0]  widx_q;
  logic [CYC_W-1:0]  cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FILL_IDLE;
      line_q  <= '0;
      widx_q  <= '0;
    end else begin
      case (state_q)
        FILL_IDLE: if (req_i) begin
          line_q  <= line_i;
          widx_q  <= '0;
          state_q <= FILL_ISSUE;
        end
        FILL_ISSUE: state_q <= FILL_STREAM;
        FILL_STREAM: if (take_i) begin
          widx_q <= widx_q + IDX_W'(1);
          if (widx_q == IDX_W'(LINE_WORDS - 1)) state_q <= FILL_IDLE;
        end
        default: state_q <= FILL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cyc_q <= '0;
    end else if (state_q == FILL_IDLE) begin
      if (req_i) cyc_q <= '0;
    end else begin
      cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  // first word each module owns lies within the first NUM_MODS words of the line
  for (genvar m = 0; m < NUM_MODS; m++) begin : g_base
    assign base_o[m] = IADDR_W'({line_q, IDX_W'(m)} >> MSHIFT);
  end

  assign launch_o      = (state_q == FILL_ISSUE);
  assign stream_o      = (state_q == FILL_STREAM);
  assign busy_o        = (state_q != FILL_IDLE);
  assign widx_o        = widx_q;
  assign fill_cycles_o = cyc_q;

endmodule

// File: rtl/ilv_line_fill.sv
module ilv_line_fill #(
  parameter int NUM_MODS   = 4,
  parameter int LINE_WORDS = 8,
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 16,
  parameter int FIRST_LAT  = 6,
  parameter int NEXT_LAT   = 4,
  parameter int CYC_W      = 8
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  req_i,
  input  logic [ADDR_W-$clog2(LINE_WORDS)-1:0]  line_i,
  output logic                                  busy_o,
  output logic                                  valid_o,
  output logic [$clog2(LINE_WORDS)-1:0]         idx_o,
  output logic [DATA_W-1:0]                     data_o,
  output logic                                  done_o,
  output logic [CYC_W-1:0]                      fill_cycles_o
);
  localparam int IDX_W   = $clog2(LINE_WORDS);
  localparam int IADDR_W = ADDR_W - $clog2(NUM_MODS);
  localparam int WPM     = LINE_WORDS / NUM_MODS;

  logic                                launch;
  logic                                stream;
  logic                                take;
  logic [IDX_W-1:0]                    widx;
  logic [NUM_MODS-1:0][IADDR_W-1:0]    base;
  logic [NUM_MODS-1:0]                 drain;
  logic [NUM_MODS-1:0]                 full;
  logic [NUM_MODS-1:0][DATA_W-1:0]     bank_data;

  ilv_fill_ctrl #(
    .NUM_MODS(NUM_MODS), .LINE_WORDS(LINE_WORDS), .ADDR_W(ADDR_W), .CYC_W(CYC_W)
  ) u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .line_i(line_i),
    .take_i(take), .launch_o(launch), .stream_o(stream), .busy_o(busy_o),
    .widx_o(widx), .base_o(base), .fill_cycles_o(fill_cycles_o)
  );

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_bank
    ilv_bank #(
      .MOD_IDX(m), .NUM_MODS(NUM_MODS), .WPM(WPM), .IADDR_W(IADDR_W),
      .DATA_W(DATA_W), .FIRST_LAT(FIRST_LAT), .NEXT_LAT(NEXT_LAT)
    ) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni), .launch_i(launch), .base_i(base[m]),
      .drain_i(drain[m]), .full_o(full[m]), .data_o(bank_data[m])
    );
  end

  ilv_return #(
    .NUM_MODS(NUM_MODS), .LINE_WORDS(LINE_WORDS), .DATA_W(DATA_W)
  ) u_ret (
    .clk_i(clk_i), .rst_ni(rst_ni), .stream_i(stream), .widx_i(widx),
    .full_i(full), .data_i(bank_data), .drain_o(drain), .take_o(take),
    .valid_o(valid_o), .idx_o(idx_o), .data_o(data_o), .done_o(done_o)
  );

endmodule

// File: rtl/ilv_line_fill_chk.sv
module ilv_line_fill_chk #(
  parameter int NUM_MODS   = 4,
  parameter int LINE_WORDS = 8,
  parameter int FIRST_LAT  = 6,
  parameter int NEXT_LAT   = 4,
  parameter int CYC_W      = 8
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          req_i,
  input logic                          busy_o,
  input logic                          valid_o,
  input logic [$clog2(LINE_WORDS)-1:0] idx_o,
  input logic                          done_o,
  input logic [CYC_W-1:0]              fill_cycles_o
);
  localparam int IDX_W   = $clog2(LINE_WORDS);
  localparam int WPM     = LINE_WORDS / NUM_MODS;
  localparam int T_PIPE  = 1 + FIRST_LAT + LINE_WORDS;
  localparam int T_BANK  = 2 + FIRST_LAT + (WPM - 1) * NEXT_LAT;
  localparam int EXP_CYC = (T_PIPE > T_BANK) ? T_PIPE : T_BANK;

  logic [IDX_W-1:0] exp_idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      exp_idx_q <= '0;
    else if (valid_o) exp_idx_q <= done_o ? '0 : exp_idx_q + IDX_W'(1);
  end

  assert_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
  assert_busy_end_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  assert_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (idx_o == exp_idx_q));
  assert_valid_in_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(busy_o));
  assert_done_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (valid_o && idx_o == IDX_W'(LINE_WORDS - 1)));
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_fill_len_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fill_cycles_o == CYC_W'(EXP_CYC)));

endmodule

bind ilv_line_fill ilv_line_fill_chk #(
  .NUM_MODS(NUM_MODS), .LINE_WORDS(LINE_WORDS), .FIRST_LAT(FIRST_LAT),
  .NEXT_LAT(NEXT_LAT), .CYC_W(CYC_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .busy_o(busy_o),
  .valid_o(valid_o), .idx_o(idx_o), .done_o(done_o), .fill_cycles_o(fill_cycles_o)
);

// File: tb/tb_ilv_line_fill.sv
module tb_ilv_line_fill;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [12:0] ln = '0;
  logic        busy, valid, done;
  logic [2:0]  idx;
  logic [15:0] data;
  logic [7:0]  cyc;

  logic        req1 = 1'b0;
  logic [12:0] ln1 = '0;
  logic        busy1, valid1, done1;
  logic [2:0]  idx1;
  logic [15:0] data1;
  logic [7:0]  cyc1;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_line_fill dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .line_i(ln), .busy_o(busy),
    .valid_o(valid), .idx_o(idx), .data_o(data), .done_o(done), .fill_cycles_o(cyc)
  );

  ilv_line_fill #(.NUM_MODS(1)) dut_one (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req1), .line_i(ln1), .busy_o(busy1),
    .valid_o(valid1), .idx_o(idx1), .data_o(data1), .done_o(done1), .fill_cycles_o(cyc1)
  );

  function automatic logic [15:0] exp_word(input logic [12:0] l, input int k);
    logic [31:0] w;
    logic [31:0] p;
    w = {16'd0, l, 3'(k)};
    p = (w * 32'd40503) ^ 32'h3C96;
    return p[15:0];
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  // four-module fill, sampled after every edge counted from acceptance
  task automatic run_fill(input logic [12:0] l, input bit intrude);
    @(negedge clk);
    req = 1'b1;
    ln  = l;
    @(negedge clk);
    req = 1'b0;
    ln  = ~l;
    chk("R2 busy after accept", 32'(busy), 1);
    for (int c = 1; c <= 15; c++) begin
      @(negedge clk);
      chk("R7 valid timing", 32'(valid), 32'(c >= 8));
      chk("R8 done timing", 32'(done), 32'(c == 15));
      chk("R2 busy span", 32'(busy), 32'(c < 15));
      if (c >= 8) begin
        chk("R6 index order", 32'(idx), 32'(c - 8));
        chk("R5 R4 data word", 32'(data), 32'(exp_word(l, c - 8)));
      end
      if (c == 15) chk("R9 fill cycles", 32'(cyc), 15);
      if (intrude) begin
        req = (c == 3);
        ln  = l ^ 13'h0A5A;
      end
    end
    req = 1'b0;
    if (intrude) begin
      for (int c = 0; c < 20; c++) begin
        @(negedge clk);
        chk("R3 ignored request", {30'd0, valid, busy}, 0);
      end
    end
  endtask

  task automatic run_single(input logic [12:0] l);
    @(negedge clk);
    req1 = 1'b1;
    ln1  = l;
    @(negedge clk);
    req1 = 1'b0;
    ln1  = ~l;
    for (int c = 1; c <= 36; c++) begin
      @(negedge clk);
      chk("R10 valid timing", 32'(valid1), 32'(c >= 8 && ((c - 8) % 4) == 0));
      chk("R10 done timing", 32'(done1), 32'(c == 36));
      if (c >= 8 && ((c - 8) % 4) == 0) begin
        chk("R10 index", 32'(idx1), 32'((c - 8) / 4));
        chk("R10 data", 32'(data1), 32'(exp_word(l, (c - 8) / 4)));
      end
      if (c == 36) chk("R10 fill cycles", 32'(cyc1), 36);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset valid", 32'(valid), 0);
    chk("R1 reset done", 32'(done), 0);
    chk("R1 reset busy", 32'(busy), 0);
    chk("R1 reset cycles", 32'(cyc), 0);
    chk("R1 reset busy one", 32'(busy1), 0);
    chk("R1 reset cycles one", 32'(cyc1), 0);

    run_fill(13'h0000, 1'b0);
    run_fill(13'h1FFF, 1'b0);
    run_fill(13'h0F0F, 1'b1);
    for (int i = 1; i < 64; i++) run_fill(13'(i * 97), 1'b0);

    run_single(13'h0000);
    run_single(13'h1FFF);
    run_single(13'h0A55);
    run_single(13'h1234);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 200000, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule